// File: doc/BRIEF.md
# Status Register Field Write Unit

This unit performs the move-to-status update of a 32-bit processor status word. A strobed request carries an instruction word, a register operand, the current mode code and the present values of the current and saved status words. The source value is either the register operand or an 8-bit immediate rotated right by an even amount. Four field bits in the instruction pick which byte lanes of the current status word take the new value. A separate select bit sends the whole value to the saved status word instead.

Write rights depend on privilege. In user mode only the condition flags can change, and any attempt to reach the saved status word is refused with a one-cycle illegal pulse. In a privileged mode the unit compares the mode field before and after the write. When the two differ, it raises a bank-switch pulse that carries both mode codes, so that the register file can swap its banked registers. The banking itself is done elsewhere.

Top module: `psr_field_writer`

## Requirements
- R1: Instruction bit 25 picks the source. When it is 1, the source is instr[7:0] rotated right by 2*instr[11:8]. When it is 0, the source is `reg_operand`.
- R2: Field bits instr[16], instr[17], instr[18] and instr[19] enable byte lanes [7:0], [15:8], [23:16] and [31:24] of the current status word. Lanes that are not enabled keep their value from `cpsr_in`.
- R3: For a privileged write to the current word (instr[22]=0), `cpsr_q` becomes (cpsr_in AND NOT mask) OR (source AND mask), and `spsr_q` becomes `spsr_in`.
- R4: When `cur_mode` is user (5'b10000) and instr[22]=0, only bits [31:28] take the source value, whatever the field bits are. Bits [27:0] keep their value from `cpsr_in`.
- R5: When `cur_mode` is user and instr[22]=1, `illegal` pulses for one cycle and neither `cpsr_q` nor `spsr_q` changes.
- R6: The mode field is bits [4:0]. In a privileged mode, when bits [4:0] of the new current word differ from `cur_mode`, `bank_sw` pulses. At the same time `bank_old_mode` shows `cur_mode` and `bank_new_mode` shows the new mode. No pulse is raised when the mode is unchanged.
- R7: In a privileged mode with instr[22]=1, `spsr_q` takes the full source value regardless of the field bits. `cpsr_q` takes `cpsr_in` unchanged, and no bank switch occurs.
- R8: Results appear on the clock edge that samples `req_valid`. `done` is high for exactly that one following cycle. Without a strobe, all state holds.
- R9: After reset, `cpsr_q` is 32'h000000D3, `spsr_q` is 0, and `done`, `illegal` and `bank_sw` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request strobe |
| instr | input | 32 | Move-to-status instruction word |
| reg_operand | input | 32 | Register source value |
| cur_mode | input | 5 | Current processor mode code |
| cpsr_in | input | 32 | Present current status word |
| spsr_in | input | 32 | Present saved status word |
| cpsr_q | output | 32 | Updated current status word |
| spsr_q | output | 32 | Updated saved status word |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Illegal-access pulse |
| bank_sw | output | 1 | Bank-switch request pulse |
| bank_old_mode | output | 5 | Mode code before the switch |
| bank_new_mode | output | 5 | Mode code after the switch |

## Verification
All results are registered once. The status words, `done`, `illegal`, `bank_sw` and both mode codes therefore all become valid together, one clock edge after the cycle in which `req_valid` is high. The bench drives each request on a falling edge, drops the strobe on the next falling edge, and compares every output at that same point, which lies half a period after the edge that captured the results. It then waits one more falling edge to confirm that the one-cycle pulses have cleared and that the words hold.

// File: rtl/psr_field_writer.sv
module psr_field_writer #(
  parameter int          W          = 32,
  parameter int          MODE_W     = 5,
  parameter logic [4:0]  USER_MODE  = 5'b10000,
  parameter logic [31:0] FLAG_MASK  = 32'hF000_0000,
  parameter logic [31:0] RESET_CPSR = 32'h0000_00D3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [W-1:0]      instr,
  input  logic [W-1:0]      reg_operand,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [W-1:0]      cpsr_in,
  input  logic [W-1:0]      spsr_in,
  output logic [W-1:0]      cpsr_q,
  output logic [W-1:0]      spsr_q,
  output logic              done,
  output logic              illegal,
  output logic              bank_sw,
  output logic [MODE_W-1:0] bank_old_mode,
  output logic [MODE_W-1:0] bank_new_mode
);
  localparam int LANES     = W / 8;
  localparam int IMM_BIT   = 25;
  localparam int SAVED_BIT = 22;
  localparam int FIELD_LSB = 16;
  localparam int ROT_LSB   = 8;

  logic [W-1:0]   imm_ext, rotated, source, lane_mask, eff_mask, merged;
  logic [2*W-1:0] imm_pair;
  logic [4:0]     rot_amt;
  logic           is_user, to_saved, wr_cur, wr_saved, illegal_c, mode_chg;

  assign rot_amt  = {instr[ROT_LSB+3:ROT_LSB], 1'b0};
  assign imm_ext  = {{(W-8){1'b0}}, instr[7:0]};
  assign imm_pair = {imm_ext, imm_ext} >> rot_amt;
  assign rotated  = imm_pair[W-1:0];
  assign source   = instr[IMM_BIT] ? rotated : reg_operand;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i*8 +: 8] = {8{instr[FIELD_LSB+i]}};
  end

  assign is_user  = (cur_mode == USER_MODE);
  assign to_saved = instr[SAVED_BIT];
  assign eff_mask = is_user ? FLAG_MASK : lane_mask;
  assign merged   = (cpsr_in & ~eff_mask) | (source & eff_mask);

  assign illegal_c = req_valid &  is_user & to_saved;
  assign wr_saved  = req_valid & ~is_user & to_saved;
  assign wr_cur    = req_valid & ~to_saved;
  assign mode_chg  = wr_cur & ~is_user & (merged[MODE_W-1:0] != cur_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q        <= RESET_CPSR;
      spsr_q        <= '0;
      done          <= 1'b0;
      illegal       <= 1'b0;
      bank_sw       <= 1'b0;
      bank_old_mode <= '0;
      bank_new_mode <= '0;
    end else begin
      done    <= req_valid;
      illegal <= illegal_c;
      bank_sw <= mode_chg;
      if (wr_cur) begin
        cpsr_q <= merged;
        spsr_q <= spsr_in;
      end
      if (wr_saved) begin
        cpsr_q <= cpsr_in;
        spsr_q <= source;
      end
      if (mode_chg) begin
        bank_old_mode <= cur_mode;
        bank_new_mode <= merged[MODE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/psr_field_writer_chk.sv
module psr_field_writer_chk #(
  parameter int          W         = 32,
  parameter int          MODE_W    = 5,
  parameter logic [4:0]  USER_MODE = 5'b10000,
  parameter logic [31:0] FLAG_MASK = 32'hF000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [W-1:0]      instr,
  input logic [MODE_W-1:0] cur_mode,
  input logic [W-1:0]      cpsr_in,
  input logic [W-1:0]      cpsr_q,
  input logic [W-1:0]      spsr_q,
  input logic              done,
  input logic              illegal,
  input logic              bank_sw,
  input logic [MODE_W-1:0] bank_old_mode,
  input logic [MODE_W-1:0] bank_new_mode
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done); // R8
  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid)); // R8
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(cpsr_q) && $stable(spsr_q) && !bank_sw)); // R5
  AST_USER_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_mode == USER_MODE && !instr[22])
      |=> ((cpsr_q & ~FLAG_MASK) == ($past(cpsr_in) & ~FLAG_MASK))); // R4
  AST_BANK_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sw |-> (bank_old_mode != bank_new_mode && bank_old_mode == $past(cur_mode)
                 && bank_new_mode == cpsr_q[MODE_W-1:0])); // R6
  AST_SAVED_KEEPS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_mode != USER_MODE && instr[22])
      |=> (cpsr_q == $past(cpsr_in) && !bank_sw)); // R7
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, bank_sw})); // R5
endmodule

bind psr_field_writer psr_field_writer_chk #(
  .W(W), .MODE_W(MODE_W), .USER_MODE(USER_MODE), .FLAG_MASK(FLAG_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
  .cur_mode(cur_mode), .cpsr_in(cpsr_in), .cpsr_q(cpsr_q), .spsr_q(spsr_q),
  .done(done), .illegal(illegal), .bank_sw(bank_sw),
  .bank_old_mode(bank_old_mode), .bank_new_mode(bank_new_mode)
);

// File: tb/psr_field_writer_test.sv
module psr_field_writer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0, reg_operand = '0, cpsr_in = '0, spsr_in = '0;
  logic [4:0]  cur_mode = 5'b10011;
  logic [31:0] cpsr_q, spsr_q;
  logic        done, illegal, bank_sw;
  logic [4:0]  bank_old_mode, bank_new_mode;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  psr_field_writer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .reg_operand(reg_operand), .cur_mode(cur_mode), .cpsr_in(cpsr_in),
    .spsr_in(spsr_in), .cpsr_q(cpsr_q), .spsr_q(spsr_q), .done(done),
    .illegal(illegal), .bank_sw(bank_sw), .bank_old_mode(bank_old_mode),
    .bank_new_mode(bank_new_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit imm, input bit saved, input logic [3:0] fld,
                                     input logic [3:0] rot, input logic [7:0] low);
    return (32'(imm) << 25) | (32'(saved) << 22) | (32'(fld) << 16) | (32'(rot) << 8) | 32'(low);
  endfunction

  // drive one request, leave the bench at the sampling point after the capturing edge
  task automatic apply(input logic [31:0] ins, input logic [31:0] rop, input logic [4:0] md,
                       input logic [31:0] cin, input logic [31:0] sin);
    @(negedge clk);
    instr = ins; reg_operand = rop; cur_mode = md; cpsr_in = cin; spsr_in = sin;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 done pulse", 32'(done), 32'd1);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    chk("R8 done clears", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 cpsr", cpsr_q, 32'h0000_00D3);
    chk("R9 spsr", spsr_q, 32'h0);
    chk("R9 strobes", {29'd0, done, illegal, bank_sw}, 32'h0);
  endtask

  task automatic t_reg_all_fields();
    apply(mk(0, 0, 4'hF, 4'h0, 8'hD3), 32'hA5A5_A5D3, 5'b10011, 32'h0000_00D3, 32'h1234_5678);
    chk("R1 R3 reg source", cpsr_q, 32'hA5A5_A5D3);
    chk("R3 spsr pass", spsr_q, 32'h1234_5678);
    chk("R6 no switch", 32'(bank_sw), 32'd0);
    after_pulse();
  endtask

  task automatic t_immediate();
    apply(mk(1, 0, 4'h8, 4'h4, 8'hF0), 32'hFFFF_FFFF, 5'b10011, 32'h0000_00D3, 32'h0);
    chk("R1 imm ror 8", cpsr_q, 32'hF000_00D3);
    after_pulse();
    apply(mk(1, 0, 4'h8, 4'h1, 8'h3F), 32'h0, 5'b10011, 32'h0000_00D3, 32'h0);
    chk("R1 imm ror 2", cpsr_q, 32'hC000_00D3);
    after_pulse();
  endtask

  task automatic t_lanes();
    for (int i = 1; i < 4; i++) begin
      apply(mk(0, 0, 4'(1 << i), 4'h0, 8'h0), 32'hFFFF_FFFF, 5'b10011, 32'h0000_0013, 32'h0);
      chk("R2 single lane", cpsr_q, 32'h0000_0013 | (32'hFF << (8 * i)));
      after_pulse();
    end
  endtask

  task automatic t_mode_change();
    apply(mk(0, 0, 4'h1, 4'h0, 8'h0), 32'h0000_0012, 5'b10011, 32'h0000_00D3, 32'h0);
    chk("R2 R6 lane0", cpsr_q, 32'h0000_0012);
    chk("R6 bank_sw", 32'(bank_sw), 32'd1);
    chk("R6 old mode", 32'(bank_old_mode), 32'h13);
    chk("R6 new mode", 32'(bank_new_mode), 32'h12);
    after_pulse();
    chk("R6 bank_sw clears", 32'(bank_sw), 32'd0);
  endtask

  task automatic t_user_write();
    apply(mk(0, 0, 4'hF, 4'h0, 8'h0), 32'hFFFF_FFFF, 5'b10000, 32'h0000_0010, 32'h0);
    chk("R4 flags only", cpsr_q, 32'hF000_0010);
    chk("R4 no switch", 32'(bank_sw), 32'd0);
    after_pulse();
  endtask

  task automatic t_user_saved();
    logic [31:0] c0, s0;
    c0 = cpsr_q; s0 = spsr_q;
    apply(mk(0, 1, 4'hF, 4'h0, 8'h0), 32'h1234_5678, 5'b10000, 32'h0000_0010, 32'h0BAD_0BAD);
    chk("R5 illegal pulse", 32'(illegal), 32'd1);
    chk("R5 cpsr held", cpsr_q, c0);
    chk("R5 spsr held", spsr_q, s0);
    after_pulse();
    chk("R5 illegal clears", 32'(illegal), 32'd0);
  endtask

  task automatic t_priv_saved();
    apply(mk(0, 1, 4'h1, 4'h0, 8'h0), 32'h6000_001F, 5'b10010, 32'h0000_0012, 32'h0);
    chk("R7 spsr full", spsr_q, 32'h6000_001F);
    chk("R7 cpsr kept", cpsr_q, 32'h0000_0012);
    chk("R7 no switch", 32'(bank_sw), 32'd0);
    after_pulse();
  endtask

  task automatic t_hold();
    logic [31:0] c0, s0;
    c0 = cpsr_q; s0 = spsr_q;
    cpsr_in = 32'hDEAD_BEEF; spsr_in = 32'hCAFE_F00D; reg_operand = 32'h0;
    repeat (3) @(negedge clk);
    chk("R8 hold cpsr", cpsr_q, c0);
    chk("R8 hold spsr", spsr_q, s0);
    chk("R8 no done", 32'(done), 32'd0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reg_all_fields();
    t_immediate();
    t_lanes();
    t_mode_change();
    t_user_write();
    t_user_saved();
    t_priv_saved();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule